// File: doc/BRIEF.md
# Serial Wire Debug Host Bring-Up and Identification Read

This block is the host end of a two-wire serial debug link. It produces the debug clock and drives a shared bidirectional data line, and it takes a freshly powered target from an unknown state into serial-wire mode. Once there, it reads the target's identification register. One `start` pulse runs the whole sequence with no further control. First comes a line reset. Then a 16-bit selection word switches the target's debug port from the scan-chain protocol to the serial-wire protocol. A second line reset and a few low idle cycles follow. Last comes a fixed read request for the debug port's identification register.

After the request the block hands the line to the target and captures what the target returns. This is a three-bit acknowledge and, when the acknowledge is OK, a 32-bit word and its parity bit. Any other acknowledge ends the transfer early. The acknowledge code stays visible, so a controller can tell a busy target, a faulting target and an absent target apart. The last case shows as all ones, because of the line pull-up. Every transfer ends with the line driven low and the clock parked low.

A "slot" is one full period of the debug clock. In each slot the host sets its data bit while the clock is low and the target's bit is captured on the rising clock.

Top module: `swd_id_probe`

## Requirements
- R1: After reset, `busy`, `done`, `swclk`, `swdio_oe`, `par_err`, `ack_code` and `id_word` are all 0.
- R2: While busy, `swclk` has a period of 2×DIV system clocks and is low when idle. The host's `swdio_o`/`swdio_oe` change only in the cycle `swclk` falls, and `swdio_i` is captured in the cycle `swclk` rises.
- R3: The first RST_CYC slots (53 by default) drive `swdio_o`=1 with `swdio_oe`=1.
- R4: The next 16 slots drive the bits of 16'hE79E least significant bit first. This is the same as 16'h79E7 sent most significant bit first.
- R5: Then RST_CYC slots drive 1, then IDLE_CYC slots (2 by default) drive 0.
- R6: The next 8 slots drive 8'hA5 LSB first: 1,0,1,0,0,1,0,1. In order these are start, debug-port select, read, two address bits, parity, stop and park.
- R7: `swdio_oe` is 0 from the slot after the request up to and including the turnaround slot after the target's last bit. The three acknowledge bits land LSB first, so the first acknowledge bit is `ack_code[0]`.
- R8: When `ack_code` is 3'b001 (OK), 32 data bits are captured LSB first into `id_word`, followed by one parity bit. `par_err` is 1 exactly when the XOR of the 32 data bits and the parity bit is 1.
- R9: For any other `ack_code`, such as 3'b010 (wait), 3'b100 (fault) or 3'b111 (no target), the block gives one turnaround slot right after the acknowledge and captures no data. `id_word` and `par_err` stay 0.
- R10: After the final turnaround slot, IDLE_CYC slots drive 0. Then `busy` falls and `done` rises, and `done` holds until the next accepted start. With the defaults an OK read lasts 172 slots and an aborted read lasts 139 slots.
- R11: A `start` pulse while `busy` is 1 is ignored and does not lengthen or restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle request to run the sequence |
| swclk | output | 1 | Debug clock to target |
| swdio_o | output | 1 | Data value driven by the host |
| swdio_oe | output | 1 | Host drive enable for the data line |
| swdio_i | input | 1 | Data line as seen at the pad |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until the next start |
| id_word | output | 32 | Captured identification word |
| ack_code | output | 3 | Captured acknowledge, first bit in bit 0 |
| par_err | output | 1 | Data parity mismatch |

## Verification
The bench builds the block with DIV=3, so each half period is an odd number of system clocks and the clock divider runs at an uneven ratio. RST_CYC=53 and IDLE_CYC=2 are kept at their defaults, which makes the expected slot positions and run lengths the ones given in R10. The bench plays the target from the debug clock alone and records every host slot. This lets it compare the complete driven bit stream and the ownership of the line, for OK, wait and absent-target answers and for a corrupted parity bit.

// File: rtl/swd_probe_pkg.sv
// Shared phase encoding and fixed link constants for the debug-link probe.
// Assumes: a single host-side sequence; no parameters live here.
package swd_probe_pkg;

    typedef enum logic [3:0] {
        PH_OFF,
        PH_RST1,
        PH_SWITCH,
        PH_RST2,
        PH_IDLE,
        PH_REQ,
        PH_TRN1,
        PH_ACK,
        PH_DATA,
        PH_PAR,
        PH_TRN2,
        PH_TAIL
    } swd_phase_e;

    // Mode-select word in LSB-first form (16'h79E7 MSB first).
    localparam logic [15:0] SEL_WORD  = 16'hE79E;
    // Identification read request in LSB-first form.
    localparam logic [7:0]  ID_REQ    = 8'hA5;
    // Acknowledge value for a successful transfer.
    localparam logic [2:0]  ACK_OK    = 3'b001;
    localparam int          SEL_BITS  = 16;
    localparam int          REQ_BITS  = 8;
    localparam int          ACK_BITS  = 3;
    localparam int          DATA_BITS = 32;

endpackage

// File: rtl/swd_clk_gen.sv
// Debug clock generator: while run is high, toggles swclk every DIV system
// clocks and flags the system-clock cycle of each rising and falling edge.
// Assumes: DIV >= 1; swclk is parked low whenever run is low.
module swd_clk_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic swclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;
    logic          wrap;

    assign wrap     = run && (div_cnt == LAST);
    assign rise_evt = wrap && !swclk;
    assign fall_evt = wrap && swclk;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            swclk   <= 1'b0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
            swclk   <= ~swclk;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !swclk) |=> !swclk); // R2

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_evt && fall_evt)); // R2

endmodule

// File: rtl/swd_seq_ctrl.sv
// Sequence controller: walks the bring-up phases slot by slot, advancing on
// each falling debug-clock edge, and decides the line value and ownership.
// Assumes: ack_code is final when the last acknowledge slot ends.
module swd_seq_ctrl
    import swd_probe_pkg::*;
#(
    parameter int RST_CYC  = 53,
    parameter int IDLE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       fall_evt,
    input  logic [2:0] ack_code,
    output swd_phase_e phase,
    output logic [1:0] slot_lo,
    output logic       start_ok,
    output logic       busy,
    output logic       done,
    output logic       drv_bit,
    output logic       drv_en
);
    localparam int MAXLEN = (RST_CYC > DATA_BITS) ? RST_CYC : DATA_BITS;
    localparam int CNTW   = $clog2(MAXLEN) + 1;

    logic [CNTW-1:0] slot;
    logic [CNTW-1:0] last_slot;
    logic            phase_end;

    assign busy     = (phase != PH_OFF);
    assign start_ok = start && !busy;
    assign slot_lo  = slot[1:0];

    // Index of the final slot in the current phase.
    always_comb begin
        unique case (phase)
            PH_RST1, PH_RST2: last_slot = CNTW'(RST_CYC - 1);
            PH_SWITCH:        last_slot = CNTW'(SEL_BITS - 1);
            PH_IDLE, PH_TAIL: last_slot = CNTW'(IDLE_CYC - 1);
            PH_REQ:           last_slot = CNTW'(REQ_BITS - 1);
            PH_ACK:           last_slot = CNTW'(ACK_BITS - 1);
            PH_DATA:          last_slot = CNTW'(DATA_BITS - 1);
            default:          last_slot = '0;
        endcase
    end

    assign phase_end = fall_evt && (slot == last_slot);

    // Phase and slot advance on each falling debug-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OFF;
            slot  <= '0;
        end else if (start_ok) begin
            phase <= PH_RST1;
            slot  <= '0;
        end else if (phase_end) begin
            slot <= '0;
            unique case (phase)
                PH_RST1:   phase <= PH_SWITCH;
                PH_SWITCH: phase <= PH_RST2;
                PH_RST2:   phase <= PH_IDLE;
                PH_IDLE:   phase <= PH_REQ;
                PH_REQ:    phase <= PH_TRN1;
                PH_TRN1:   phase <= PH_ACK;
                PH_ACK:    phase <= (ack_code == ACK_OK) ? PH_DATA : PH_TRN2;
                PH_DATA:   phase <= PH_PAR;
                PH_PAR:    phase <= PH_TRN2;
                PH_TRN2:   phase <= PH_TAIL;
                default:   phase <= PH_OFF;
            endcase
        end else if (fall_evt) begin
            slot <= slot + 1'b1;
        end
    end

    // Completion flag, held until the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) begin
            done <= 1'b0;
        end else if (phase_end && phase == PH_TAIL) begin
            done <= 1'b1;
        end
    end

    // Host line value and ownership per phase.
    always_comb begin
        drv_en  = 1'b0;
        drv_bit = 1'b0;
        unique case (phase)
            PH_RST1, PH_RST2: begin drv_en = 1'b1; drv_bit = 1'b1; end
            PH_SWITCH: begin drv_en = 1'b1; drv_bit = SEL_WORD[slot[3:0]]; end
            PH_IDLE, PH_TAIL: begin drv_en = 1'b1; drv_bit = 1'b0; end
            PH_REQ:    begin drv_en = 1'b1; drv_bit = ID_REQ[slot[2:0]]; end
            default:   begin drv_en = 1'b0; drv_bit = 1'b0; end
        endcase
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !phase_end) |=> (busy && !done)); // R11

    AST_NO_DATA_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |-> (ack_code == ACK_OK)); // R9

endmodule

// File: rtl/swd_rx_capture.sv
// Receive capture: stores acknowledge and data bits sampled on rising debug
// clock edges and compares the received parity bit with the data.
// Assumes: the phase and slot index are stable across each rising edge.
module swd_rx_capture
    import swd_probe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        busy,
    input  logic        rise_evt,
    input  swd_phase_e  phase,
    input  logic [1:0]  slot_lo,
    input  logic        din,
    output logic [2:0]  ack_code,
    output logic [31:0] id_word,
    output logic        par_err
);
    // Sample target bits into acknowledge, data and parity state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ack_code <= '0;
            id_word  <= '0;
            par_err  <= 1'b0;
        end else if (rise_evt) begin
            unique case (phase)
                PH_ACK:  ack_code[slot_lo] <= din;
                PH_DATA: id_word <= {din, id_word[31:1]};
                PH_PAR:  par_err <= (^id_word) ^ din;
                default: ;
            endcase
        end
    end

    AST_ID_ONLY_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable(id_word)) |-> (ack_code == ACK_OK)); // R9

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && $past(phase) != PH_ACK) |-> $stable(ack_code)); // R7

endmodule

// File: rtl/swd_id_probe.sv
// Top: serial-wire debug host that brings a target into serial-wire mode
// and reads its identification register after one start pulse.
// Assumes: swdio_i is the pad value, pulled high when nobody drives it.
module swd_id_probe #(
    parameter int DIV      = 2,
    parameter int RST_CYC  = 53,
    parameter int IDLE_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        swclk,
    output logic        swdio_o,
    output logic        swdio_oe,
    input  logic        swdio_i,
    output logic        busy,
    output logic        done,
    output logic [31:0] id_word,
    output logic [2:0]  ack_code,
    output logic        par_err
);
    import swd_probe_pkg::*;

    swd_phase_e phase;
    logic [1:0] slot_lo;
    logic       start_ok;
    logic       rise_evt;
    logic       fall_evt;

    swd_clk_gen #(.DIV(DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .swclk    (swclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    swd_seq_ctrl #(.RST_CYC(RST_CYC), .IDLE_CYC(IDLE_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .fall_evt (fall_evt),
        .ack_code (ack_code),
        .phase    (phase),
        .slot_lo  (slot_lo),
        .start_ok (start_ok),
        .busy     (busy),
        .done     (done),
        .drv_bit  (swdio_o),
        .drv_en   (swdio_oe)
    );

    swd_rx_capture u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_ok),
        .busy     (busy),
        .rise_evt (rise_evt),
        .phase    (phase),
        .slot_lo  (slot_lo),
        .din      (swdio_i),
        .ack_code (ack_code),
        .id_word  (id_word),
        .par_err  (par_err)
    );

    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        swdio_oe |-> busy); // R7

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable({swdio_o, swdio_oe})) |-> $fell(swclk)); // R2

endmodule

// File: tb/swd_id_probe_tb.sv
// Directed bench: plays the target from the debug clock, records every host
// slot and checks the driven stream, line ownership and captured results.
module swd_id_probe_tb;
    localparam int DIV   = 3;
    localparam int RST   = 53;
    localparam int IDLE  = 2;
    localparam int PRE   = 2 * RST + 16 + IDLE + 8;   // host slots before turnaround
    localparam int ACK0  = PRE + 1;
    localparam int D0    = ACK0 + 3;
    localparam int PSLOT = D0 + 32;
    localparam int N_OK  = PSLOT + 2 + IDLE;          // 172
    localparam int N_BAD = ACK0 + 3 + 1 + IDLE;       // 139

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        swclk, swdio_o, swdio_oe, busy, done, par_err;
    logic        swdio_i = 1'b1;
    logic [31:0] id_word;
    logic [2:0]  ack_code;

    int n_chk = 0;
    int n_fail = 0;

    logic        rec_o  [0:255];
    logic        rec_oe [0:255];
    int          rc = 0;
    time         t_rise [0:2];
    logic [2:0]  t_ack = 3'b111;
    logic [31:0] t_data = '0;
    logic        t_flip = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    swd_id_probe #(.DIV(DIV), .RST_CYC(RST), .IDLE_CYC(IDLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .swclk(swclk),
        .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i),
        .busy(busy), .done(done), .id_word(id_word),
        .ack_code(ack_code), .par_err(par_err)
    );

    // Target side: record host slot on rising clock.
    always @(posedge swclk) begin
        if (rc < 256) begin
            rec_o[rc]  = swdio_o;
            rec_oe[rc] = swdio_oe;
        end
        if (rc < 3) t_rise[rc] = $time;
        rc = rc + 1;
    end

    // Target side: present the response for the next slot on falling clock.
    always @(negedge swclk) begin
        if (rc >= ACK0 && rc < D0)
            swdio_i = t_ack[rc - ACK0];
        else if (rc >= D0 && rc < PSLOT && t_ack == 3'b001)
            swdio_i = t_data[rc - D0];
        else if (rc == PSLOT && t_ack == 3'b001)
            swdio_i = (^t_data) ^ t_flip;
        else
            swdio_i = 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_host(input int k);
        logic [15:0] sw;
        logic [7:0]  rq;
        sw = 16'hE79E;
        rq = 8'hA5;
        if (k < RST) return 1'b1;
        if (k < RST + 16) return sw[k - RST];
        if (k < 2 * RST + 16) return 1'b1;
        if (k < 2 * RST + 16 + IDLE) return 1'b0;
        return rq[k - (2 * RST + 16 + IDLE)];
    endfunction

    task automatic run_seq(input logic [2:0] ack, input logic [31:0] data,
                           input logic flip, input logic restart);
        t_ack  = ack;
        t_data = data;
        t_flip = flip;
        rc     = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            repeat (200) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    task automatic check_stream(input int total);
        int e3 = 0, e4 = 0, e5 = 0, e6 = 0, e7 = 0, e10 = 0;
        for (int k = 0; k < PRE; k++) begin
            if (rec_oe[k] !== 1'b1 || rec_o[k] !== exp_host(k)) begin
                if (k < RST) e3++;
                else if (k < RST + 16) e4++;
                else if (k < 2 * RST + 16 + IDLE) e5++;
                else e6++;
            end
        end
        for (int k = PRE; k < total - IDLE; k++)
            if (rec_oe[k] !== 1'b0) e7++;
        for (int k = total - IDLE; k < total; k++)
            if (rec_oe[k] !== 1'b1 || rec_o[k] !== 1'b0) e10++;
        check("R3 line reset slots", 64'(e3), 64'd0);
        check("R4 switch word slots", 64'(e4), 64'd0);
        check("R5 reset and idle slots", 64'(e5), 64'd0);
        check("R6 request slots", 64'(e6), 64'd0);
        check("R7 line released", 64'(e7), 64'd0);
        check("R10 tail low slots", 64'(e10), 64'd0);
        check("R10 slot count", 64'(rc), 64'(total));
    endtask

    task automatic t_reset;
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 swclk", 64'(swclk), 64'd0);
        check("R1 oe", 64'(swdio_oe), 64'd0);
        check("R1 results", {28'd0, par_err, ack_code, id_word}, 64'd0);
    endtask

    task automatic t_ok_read;
        run_seq(3'b001, 32'h0BC1_1477, 1'b0, 1'b1);
        check_stream(N_OK);
        check("R2 clock period", 64'(t_rise[2] - t_rise[1]), 64'(2 * DIV * 20));
        check("R8 id word", 64'(id_word), 64'h0BC1_1477);
        check("R8 ack ok", 64'(ack_code), 64'd1);
        check("R8 parity ok", 64'(par_err), 64'd0);
        check("R11 restart ignored length", 64'(rc), 64'(N_OK));
        repeat (30) @(negedge clk);
        check("R10 done held", {busy, done, swclk}, 64'b010);
    endtask

    task automatic t_parity_bad;
        run_seq(3'b001, 32'hFFFF_FFFF, 1'b1, 1'b0);
        check("R8 id all ones", 64'(id_word), 64'hFFFF_FFFF);
        check("R8 parity error", 64'(par_err), 64'd1);
    endtask

    task automatic t_wait_ack;
        run_seq(3'b010, 32'hDEAD_BEEF, 1'b0, 1'b0);
        check_stream(N_BAD);
        check("R9 wait code", 64'(ack_code), 64'b010);
        check("R9 no data", {31'd0, par_err, id_word}, 64'd0);
    endtask

    task automatic t_no_target;
        run_seq(3'b111, 32'h1234_5678, 1'b0, 1'b0);
        check("R9 absent code", 64'(ack_code), 64'b111);
        check("R9 absent no data", 64'(id_word), 64'd0);
        check("R9 absent length", 64'(rc), 64'(N_BAD));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ok_read();
        t_parity_bad();
        t_wait_ack();
        t_no_target();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule